// File: doc/BRIEF.md
# Multi-Stage Prescaled Interval Timer

This block holds a bank of interval timers. Each timer runs a counter chain driven by one shared tick strobe. The first stage is a fractional prescaler: on every tick it adds a shared step value to an accumulator. When the accumulator reaches the timer's own frequency threshold, the threshold is subtracted and the remainder is kept. Each such overflow flips a divided bit.

The divided bit passes through a global gate to form a gated line. The gate holds the line low while the global run control is low or the global halt control is high. Every 1-to-0 transition of the gated line is a count event. The gate is re-evaluated on every cycle, so closing the gate while the divided bit is high also produces an event.

An enabled timer counts events in an 8-bit interval counter. When the interval counter reaches the timer's target, it restarts from zero and a 4-bit output counter advances. Software reads the output counters through a read port, and each read clears the counter it returned.

Top module: `tmr_top`

## Requirements
- R1: On a clock edge with `tick` high, each prescaler accumulator adds `step`. With `tick` low, every accumulator keeps its value.
- R2: When accumulator plus `step` is greater than or equal to the timer's threshold, the accumulator becomes the sum minus the threshold, so the remainder is kept. This is defined for 0 < `step` <= threshold.
- R3: Each prescaler overflow inverts that timer's divided bit, in the same cycle as the overflow.
- R4: The gated line is 0 whenever `gateOn` is 0 or `gateOff` is 1. Otherwise it equals the divided bit.
- R5: The gated line is evaluated on every clock edge, using the updated divided bit and the current gate inputs. A count event occurs exactly when the line goes from 1 to 0, including a transition caused only by a change of the gate inputs.
- R6: A count event on a timer whose enable bit is 0 has no effect on that timer.
- R7: On an accepted count event, the 8-bit interval counter increments. If the incremented value equals the 8-bit target, the interval counter becomes 0 and the output counter increments. A target of 0 acts as 256.
- R8: The output counter is 4 bits wide and wraps from 15 to 0.
- R9: `rdData` shows the output counter of timer `rdSel` combinationally. Timer indices are 0 to 2, and any other index reads as 0. With `rdStb` high, that counter is cleared at the clock edge. If it also increments at that edge, it becomes 1.
- R10: A 0-to-1 change of a timer's enable bit clears its interval and output counters at that edge. This clear takes precedence over a count event and a read.
- R11: Three timers share `tick`, `step` and the gate inputs, but each has its own threshold, enable and target, and each counts independently. Timer k uses bits [8k+7:8k] of `freqThr` and of `target`, and bit k of `tmrEn`.
- R12: After reset, all accumulators, divided bits, gated lines and counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler advance strobe |
| step | input | 8 | Value added to each accumulator on a tick |
| gateOn | input | 1 | Global run control; low forces the gated lines low |
| gateOff | input | 1 | Global halt control; high forces the gated lines low |
| freqThr | input | 24 | Per-timer prescaler thresholds, 8 bits each |
| tmrEn | input | 3 | Per-timer enable |
| target | input | 24 | Per-timer interval targets, 8 bits each |
| rdStb | input | 1 | Read-and-clear strobe |
| rdSel | input | 2 | Timer index for the read port |
| rdData | output | 4 | Output counter of the selected timer |

## Verification
The only observable state is the output counters, so a wrong internal value shows up as a wrong count at the next read. Some errors are a prescaler that loses its remainder, a missed gate-induced edge, or an interval counter that does not restart. Each of these shifts the counter by at least one within one target period of events, and the bench reads every timer often enough to see that. Sweeps over thresholds, steps and targets, together with random gate, enable and read activity, are compared against an arithmetic reference model that is advanced every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Per-timer strobes from control to datapath
  typedef struct packed {
    logic countEvt;  // accepted falling edge of the gated line
    logic clrCnt;    // enable rose: clear interval and output counters
    logic rdClr;     // read port clears the output counter
  } tmrStrb_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [ACC_W-1:0] step,
  input  logic [ACC_W-1:0] thr,
  output logic [ACC_W-1:0] accOut,
  output logic             divNext
);
  logic [ACC_W-1:0] accQ, accD;
  logic [ACC_W:0]   accSum;
  logic             divQ, ovf;

  always_comb begin
    accSum = {1'b0, accQ} + {1'b0, step};
    ovf    = tick && (accSum >= {1'b0, thr});
    if (!tick)   accD = accQ;
    else if (ovf) accD = ACC_W'(accSum - {1'b0, thr});
    else          accD = accSum[ACC_W-1:0];
    divNext = divQ ^ ovf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      divQ <= 1'b0;
    end else begin
      accQ <= accD;
      divQ <= divNext;
    end
  end

  assign accOut = accQ;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl import tmr_pkg::*; #(
  parameter int NUM_TMR = 3,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               gateOn,
  input  logic               gateOff,
  input  logic [NUM_TMR-1:0] tmrEn,
  input  logic               rdStb,
  input  logic [SEL_W-1:0]   rdSel,
  input  logic [NUM_TMR-1:0] divNext,
  output tmrStrb_t           strb [NUM_TMR]
);
  logic [NUM_TMR-1:0] lineQ, lineNow, fall, enPrevQ, enRise;
  logic               gateOpen;

  assign gateOpen = gateOn && !gateOff;

  always_comb begin
    for (int i = 0; i < NUM_TMR; i++) begin
      lineNow[i]         = divNext[i] && gateOpen;
      fall[i]            = lineQ[i] && !lineNow[i];
      enRise[i]          = tmrEn[i] && !enPrevQ[i];
      strb[i].clrCnt     = enRise[i];
      strb[i].countEvt   = fall[i] && tmrEn[i] && !enRise[i];
      strb[i].rdClr      = rdStb && (rdSel == SEL_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ   <= '0;
      enPrevQ <= '0;
    end else begin
      lineQ   <= lineNow;
      enPrevQ <= tmrEn;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath import tmr_pkg::*; #(
  parameter int NUM_TMR = 3,
  parameter int ACC_W   = 8,
  parameter int TGT_W   = 8,
  parameter int OUT_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tick,
  input  logic [ACC_W-1:0]           step,
  input  logic [NUM_TMR*ACC_W-1:0]   freqThr,
  input  logic [NUM_TMR*TGT_W-1:0]   target,
  input  tmrStrb_t                   strb [NUM_TMR],
  output logic [NUM_TMR-1:0]         divNext,
  output logic [NUM_TMR*ACC_W-1:0]   accVec,
  output logic [NUM_TMR*TGT_W-1:0]   s2Vec,
  output logic [NUM_TMR*OUT_W-1:0]   s3Vec
);
  for (genvar g = 0; g < NUM_TMR; g++) begin : gTmr
    logic [TGT_W-1:0] s2Q, s2Inc;
    logic [OUT_W-1:0] s3Q;
    logic             hit;

    tmr_prescale #(.ACC_W(ACC_W)) uPre (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (tick),
      .step   (step),
      .thr    (freqThr[g*ACC_W +: ACC_W]),
      .accOut (accVec[g*ACC_W +: ACC_W]),
      .divNext(divNext[g])
    );

    assign s2Inc = s2Q + 1'b1;  // 8-bit wrap makes target 0 act as 256
    assign hit   = strb[g].countEvt && (s2Inc == target[g*TGT_W +: TGT_W]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        s2Q <= '0;
        s3Q <= '0;
      end else if (strb[g].clrCnt) begin
        s2Q <= '0;
        s3Q <= '0;
      end else begin
        if (strb[g].countEvt) s2Q <= hit ? '0 : s2Inc;
        if (strb[g].rdClr)    s3Q <= OUT_W'(hit);
        else if (hit)         s3Q <= s3Q + 1'b1;
      end
    end

    assign s2Vec[g*TGT_W +: TGT_W] = s2Q;
    assign s3Vec[g*OUT_W +: OUT_W] = s3Q;
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top import tmr_pkg::*; #(
  parameter  int NUM_TMR = 3,
  parameter  int ACC_W   = 8,
  parameter  int TGT_W   = 8,
  parameter  int OUT_W   = 4,
  localparam int SEL_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick,
  input  logic [ACC_W-1:0]         step,
  input  logic                     gateOn,
  input  logic                     gateOff,
  input  logic [NUM_TMR*ACC_W-1:0] freqThr,
  input  logic [NUM_TMR-1:0]       tmrEn,
  input  logic [NUM_TMR*TGT_W-1:0] target,
  input  logic                     rdStb,
  input  logic [SEL_W-1:0]         rdSel,
  output logic [OUT_W-1:0]         rdData
);
  tmrStrb_t                 strb [NUM_TMR];
  logic [NUM_TMR-1:0]       divNext;
  logic [NUM_TMR*ACC_W-1:0] accVec;
  logic [NUM_TMR*TGT_W-1:0] s2Vec;
  logic [NUM_TMR*OUT_W-1:0] s3Vec;

  tmr_ctrl #(.NUM_TMR(NUM_TMR), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .gateOn(gateOn), .gateOff(gateOff),
    .tmrEn(tmrEn), .rdStb(rdStb), .rdSel(rdSel),
    .divNext(divNext), .strb(strb)
  );

  tmr_datapath #(.NUM_TMR(NUM_TMR), .ACC_W(ACC_W), .TGT_W(TGT_W), .OUT_W(OUT_W)) uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .step(step),
    .freqThr(freqThr), .target(target), .strb(strb),
    .divNext(divNext), .accVec(accVec), .s2Vec(s2Vec), .s3Vec(s3Vec)
  );

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_TMR; i++)
      if (rdSel == SEL_W'(i)) rdData = s3Vec[i*OUT_W +: OUT_W];
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk import tmr_pkg::*; #(
  parameter int NUM_TMR = 3,
  parameter int ACC_W   = 8,
  parameter int TGT_W   = 8,
  parameter int OUT_W   = 4,
  parameter int SEL_W   = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     tick,
  input logic                     gateOn,
  input logic                     gateOff,
  input logic [NUM_TMR-1:0]       tmrEn,
  input logic                     rdStb,
  input logic [SEL_W-1:0]         rdSel,
  input tmrStrb_t                 strb [NUM_TMR],
  input logic [NUM_TMR*ACC_W-1:0] accVec,
  input logic [NUM_TMR*TGT_W-1:0] s2Vec,
  input logic [NUM_TMR*OUT_W-1:0] s3Vec
);
  logic gateShut;
  logic rd0;
  assign gateShut = gateOff || !gateOn;
  assign rd0      = rdStb && (rdSel == '0);

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(accVec)); // R1

  AST_GATE_SHUT_NO_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (gateShut && $past(gateShut)) |-> !strb[0].countEvt); // R4

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!tmrEn[0] && !rd0) |=> ($stable(s2Vec[TGT_W-1:0]) && $stable(s3Vec[OUT_W-1:0]))); // R6

  AST_OUT_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!rd0 && !strb[0].clrCnt) |=>
      (OUT_W'(s3Vec[OUT_W-1:0] - $past(s3Vec[OUT_W-1:0])) <= OUT_W'(1))); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rd0 |=> (s3Vec[OUT_W-1:0] <= OUT_W'(1))); // R9

  AST_EN_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (tmrEn[0] && !$past(tmrEn[0])) |=>
      (s2Vec[TGT_W-1:0] == '0 && s3Vec[OUT_W-1:0] == '0)); // R10
endmodule

bind tmr_top tmr_chk #(
  .NUM_TMR(NUM_TMR), .ACC_W(ACC_W), .TGT_W(TGT_W), .OUT_W(OUT_W), .SEL_W(SEL_W)
) i_tmr_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .gateOn(gateOn), .gateOff(gateOff),
  .tmrEn(tmrEn), .rdStb(rdStb), .rdSel(rdSel), .strb(strb),
  .accVec(accVec), .s2Vec(s2Vec), .s3Vec(s3Vec)
);

// File: tb/test_tmr_top.sv
`timescale 1ns/1ps
module test_tmr_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  step = 8'd1;
  logic        gateOn = 1'b0, gateOff = 1'b0;
  logic [7:0]  thr [3];
  logic [7:0]  tgt [3];
  logic [2:0]  tmrEn = 3'b000;
  logic        rdStb = 1'b0;
  logic [1:0]  rdSel = 2'd0;
  logic [3:0]  rdData;
  logic [23:0] freqThr, target;

  int   nChk = 0, nFail = 0;
  bit   done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  string tag = "R12";

  // reference model state
  int mAcc [3], mS1 [3], mLine [3], mEnP [3], mS2 [3], mS3 [3];

  assign freqThr = {thr[2], thr[1], thr[0]};
  assign target  = {tgt[2], tgt[1], tgt[0]};

  always #2.5 clk = ~clk;

  tmr_top i_tmr_top (
    .clk(clk), .rstN(rstN), .tick(tick), .step(step), .gateOn(gateOn),
    .gateOff(gateOff), .freqThr(freqThr), .tmrEn(tmrEn), .target(target),
    .rdStb(rdStb), .rdSel(rdSel), .rdData(rdData)
  );

  task automatic modelStep();
    for (int i = 0; i < 3; i++) begin
      int sum, ln, fall, rise, inc, rdc;
      sum = mAcc[i] + int'(step);
      if (tick) begin
        if (sum >= int'(thr[i])) begin
          mAcc[i] = sum - int'(thr[i]);
          mS1[i]  = mS1[i] ^ 1;
        end else mAcc[i] = sum;
      end
      ln   = (mS1[i] == 1 && gateOn && !gateOff) ? 1 : 0;
      fall = (mLine[i] == 1 && ln == 0) ? 1 : 0;
      mLine[i] = ln;
      rise = (tmrEn[i] && mEnP[i] == 0) ? 1 : 0;
      mEnP[i] = int'(tmrEn[i]);
      rdc = (rdStb && int'(rdSel) == i) ? 1 : 0;
      if (rise == 1) begin
        mS2[i] = 0;
        mS3[i] = 0;
      end else begin
        inc = 0;
        if (fall == 1 && tmrEn[i]) begin
          mS2[i] = (mS2[i] + 1) % 256;
          if (mS2[i] == int'(tgt[i])) begin
            mS2[i] = 0;
            inc = 1;
          end
        end
        mS3[i] = (rdc == 1) ? inc : (mS3[i] + inc) % 16;
      end
    end
  endtask

  // inputs are stable here (just after a falling edge)
  task automatic runCycle(input bit chk);
    if (chk && rdStb) begin
      int exp;
      #1;
      exp = (rdSel < 2'd3) ? mS3[rdSel] : 0;
      nChk++;
      if (int'(rdData) != exp) begin
        nFail++;
        $display("FAIL %s timer %0d: rdData=%0d expected %0d", tag, rdSel, rdData, exp);
      end
    end
    @(posedge clk);
    modelStep();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(negedge clk);
  endtask

  task automatic readAll(input string t);
    tag = t;
    for (int i = 0; i < 3; i++) begin
      rdStb = 1'b1;
      rdSel = 2'(i);
      tick  = 1'b0;
      runCycle(1'b1);
    end
    rdStb = 1'b0;
  endtask

  task automatic runSweep(input int nCyc, input bit tickAlways);
    for (int c = 0; c < nCyc; c++) begin
      tick  = tickAlways ? 1'b1 : (lfsr[1:0] != 2'b00);   // R1: idle ticks too
      rdStb = (lfsr[6:4] == 3'b000);                      // R9: reads mid-run
      rdSel = lfsr[9:8];
      tag   = "R9 R1";
      runCycle(1'b1);
    end
    rdStb = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      thr[i] = 8'd1; tgt[i] = 8'd1;
      mAcc[i] = 0; mS1[i] = 0; mLine[i] = 0; mEnP[i] = 0; mS2[i] = 0; mS3[i] = 0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R12: reset state, including an out-of-range read index
    readAll("R12");
    rdStb = 1'b1; rdSel = 2'd3; tag = "R12 R9";
    runCycle(1'b1);
    rdStb = 1'b0;

    // Sweep of thresholds, steps and targets across three timers
    gateOn = 1'b1; gateOff = 1'b0;
    for (int th = 1; th <= 4; th++) begin
      for (int st = 1; st <= th; st++) begin
        thr[0] = 8'(th); thr[1] = 8'(th + 1); thr[2] = 8'(th + 2);
        tgt[0] = 8'(st); tgt[1] = 8'(th); tgt[2] = 8'(th + st);
        step   = 8'(st);
        tmrEn  = 3'b000; runCycle(1'b0);
        tmrEn  = 3'b111; runCycle(1'b0);             // R10 clear on rise
        runSweep(160, 1'b0);
        readAll("R1 R2 R3 R7 R8 R11");
      end
    end

    // R7: target 0 acts as 256; R8 wrap with target 1
    thr[0] = 8'd1; thr[1] = 8'd1; thr[2] = 8'd1; step = 8'd1;
    tgt[0] = 8'd1; tgt[1] = 8'd2; tgt[2] = 8'd0;
    tmrEn = 3'b000; runCycle(1'b0);
    tmrEn = 3'b111;
    for (int c = 0; c < 1100; c++) begin
      tick = 1'b1; rdStb = 1'b0;
      runCycle(1'b0);
    end
    readAll("R7 R8");

    // R4 R5: gate inputs change while the divided bits run
    thr[0] = 8'd2; thr[1] = 8'd3; thr[2] = 8'd2; step = 8'd1;
    tgt[0] = 8'd1; tgt[1] = 8'd1; tgt[2] = 8'd2;
    for (int c = 0; c < 3000; c++) begin
      tick    = lfsr[0];
      if (lfsr[3:2] == 2'b00) gateOn  = ~gateOn;
      if (lfsr[11:9] == 3'b000) gateOff = ~gateOff;
      rdStb   = (lfsr[6:5] == 2'b00);
      rdSel   = lfsr[8:7];
      tag     = "R4 R5 R9";
      runCycle(1'b1);
    end
    rdStb = 1'b0;
    readAll("R4 R5");

    // R6 R10: enables toggling, reads while disabled
    gateOn = 1'b1; gateOff = 1'b0;
    thr[0] = 8'd1; thr[1] = 8'd2; thr[2] = 8'd1;
    tgt[0] = 8'd1; tgt[1] = 8'd1; tgt[2] = 8'd3;
    for (int c = 0; c < 3000; c++) begin
      tick  = 1'b1;
      for (int i = 0; i < 3; i++)
        if (lfsr[4*i +: 4] == 4'h0) tmrEn[i] = ~tmrEn[i];
      rdStb = (lfsr[14:13] == 2'b00);
      rdSel = lfsr[1:0];
      tag   = "R6 R10 R9";
      runCycle(1'b1);
    end
    rdStb = 1'b0;
    readAll("R6 R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule